// File: doc/BRIEF.md
# SPI Command Response Checker

This block runs the answer phase of a command exchange on an SPI link, after the command frame has left the host. It fetches received bytes one at a time from an SPI byte engine by pulsing a read request. It then checks that the target first echoes the opcode being answered and then returns a zero status byte. Each of the two polling phases has a bounded number of attempts. When the target is answered by the reset command, one received byte is thrown away before the echo search begins.

The result is a one-cycle completion pulse with a pass/fail flag beside it. A read error reported by the byte engine cuts the check short with a fail. Frame generation and the data phases that follow a successful response are handled elsewhere.

Top module: `spi_resp_checker`

## Requirements
- R1: After reset, `done`, `fail` and `rd_req` are all low, and they stay low until `start` is pulsed.
- R2: A `start` pulse sampled while idle makes `rd_req` high in the next cycle. `rd_req` is high for exactly one cycle per requested byte. No new request is issued until the byte engine has returned the previous byte with `rx_valid`.
- R3: When the latched opcode equals the reset opcode (parameter `RST_OPC`, default 0xCF), the first returned byte is discarded whatever its value. It counts toward neither polling phase.
- R4: In the echo phase, bytes are requested until one equals the latched opcode. At most `RETRIES`+1 bytes are read (11 with the default of 10). If all of them differ, the check ends with fail.
- R5: The status phase begins only after an echo match. It reads until a byte equals `OK_CODE` (default 0x00), with its own budget of `RETRIES`+1 reads. If all of them differ, the check ends with fail; a match ends it with pass.
- R6: A returned byte with `rx_err` high ends the check at once with fail, in any phase.
- R7: `done` is a one-cycle pulse in the cycle after the deciding byte is returned. `fail` is valid only while `done` is high (high means fail, low means pass) and is low at all other times.
- R8: A `start` pulse while a check is in progress is ignored. An `rx_valid` with no request outstanding is ignored, even when `rx_err` is set with it.
- R9: The opcode is latched on the accepted `start`. Later changes on `opcode` do not affect the running check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a response check (one-cycle pulse) |
| opcode | input | 8 | Opcode of the command being answered |
| rx_valid | input | 1 | Byte engine returns a received byte |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Byte engine reports a read error with this byte |
| rd_req | output | 1 | Request one received byte from the byte engine |
| done | output | 1 | Check complete (one-cycle pulse) |
| fail | output | 1 | Check result, valid with `done` |

## Verification
A phase register that advances too early or too late changes the number of `rd_req` pulses before `done`. That count is compared against a model for every script, so such a fault shows by the end of the same check. A retry counter off by one shows only at the budget boundary, so scripts with exactly 10 and exactly 11 mismatches sit on both sides of the limit in each phase. A lost discard for the reset opcode is exposed by a script whose outcome flips when the discarded byte is counted. A mishandled error flag or stray byte shows as a wrong `fail` value or a premature `done`.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_DISCARD = 2'd0,
    ST_ECHO    = 2'd1,
    ST_STATUS  = 2'd2
  } stage_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_FIN   = 2'd3
  } seq_t;

  // First stage of a check: the reset opcode throws one byte away first
  function automatic stage_t entry_stage(logic [BYTE_W-1:0] opc,
                                         logic [BYTE_W-1:0] rst_opc);
    return (opc == rst_opc) ? ST_DISCARD : ST_ECHO;
  endfunction

  // Whether a returned byte ends the current stage
  function automatic logic byte_hits(stage_t st, logic [BYTE_W-1:0] b,
                                     logic [BYTE_W-1:0] opc,
                                     logic [BYTE_W-1:0] ok_code);
    case (st)
      ST_DISCARD: return 1'b1;
      ST_ECHO:    return b == opc;
      default:    return b == ok_code;
    endcase
  endfunction

  function automatic stage_t next_stage(stage_t st);
    return (st == ST_DISCARD) ? ST_ECHO : ST_STATUS;
  endfunction
endpackage

// File: rtl/rsp_poll_budget.sv
module rsp_poll_budget #(
  parameter int RETRIES = 10,
  localparam int CNT_W = $clog2(RETRIES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic exhausted
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (bump && !exhausted) cnt <= cnt + 1'b1;
  end

  assign exhausted = (cnt == CNT_W'(RETRIES));

  AST_BUDGET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(RETRIES)); // R4
endmodule

// File: rtl/rsp_byte_judge.sv
module rsp_byte_judge
  import rsp_pkg::*;
#(
  parameter logic [BYTE_W-1:0] OK_CODE = 8'h00
) (
  input  stage_t            stage,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] opc,
  output logic              hit
);
  assign hit = byte_hits(stage, rx_byte, opc, OK_CODE);
endmodule

// File: rtl/rsp_seq_fsm.sv
module rsp_seq_fsm
  import rsp_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RST_OPC = 8'hCF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] opcode,
  input  logic              rx_valid,
  input  logic              rx_err,
  input  logic              hit,
  input  logic              exhausted,
  output stage_t            stage,
  output logic [BYTE_W-1:0] opc_q,
  output logic              budget_clr,
  output logic              budget_bump,
  output logic              rd_req,
  output logic              done,
  output logic              fail
);
  seq_t state;
  logic fail_q;

  // named events for the assertions
  logic take, accept_start, take_ok, take_miss;
  assign accept_start = (state == S_IDLE) && start;
  assign take         = (state == S_WAIT) && rx_valid;
  assign take_ok      = take && !rx_err && hit;
  assign take_miss    = take && !rx_err && !hit;

  assign budget_clr  = accept_start || take_ok;
  assign budget_bump = take_miss;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      stage  <= ST_ECHO;
      opc_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          opc_q  <= opcode;
          stage  <= entry_stage(opcode, RST_OPC);
          fail_q <= 1'b0;
          state  <= S_ISSUE;
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (rx_valid) begin
          if (rx_err) begin
            fail_q <= 1'b1;
            state  <= S_FIN;
          end else if (hit) begin
            if (stage == ST_STATUS) begin
              fail_q <= 1'b0;
              state  <= S_FIN;
            end else begin
              stage <= next_stage(stage);
              state <= S_ISSUE;
            end
          end else if (exhausted) begin
            fail_q <= 1'b1;
            state  <= S_FIN;
          end else begin
            state <= S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rd_req = (state == S_ISSUE);
  assign done   = (state == S_FIN);
  assign fail   = done && fail_q;

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R2
  AST_START_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start |=> rd_req); // R2
  AST_ERR_ENDS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rx_err) |=> (done && fail)); // R6
  AST_STATUS_AFTER_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_STATUS && $past(stage) != ST_STATUS)
      |-> ($past(stage) == ST_ECHO && $past(take_ok))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done); // R7
  AST_OPC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(opc_q)); // R9
endmodule

// File: rtl/spi_resp_checker.sv
module spi_resp_checker
  import rsp_pkg::*;
#(
  parameter int                RETRIES = 10,
  parameter logic [BYTE_W-1:0] RST_OPC = 8'hCF,
  parameter logic [BYTE_W-1:0] OK_CODE = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] opcode,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_err,
  output logic              rd_req,
  output logic              done,
  output logic              fail
);
  stage_t            stage;
  logic [BYTE_W-1:0] opc_q;
  logic              hit, exhausted, budget_clr, budget_bump;

  rsp_byte_judge #(.OK_CODE(OK_CODE)) u_judge (
    .stage(stage), .rx_byte(rx_data), .opc(opc_q), .hit(hit)
  );

  rsp_poll_budget #(.RETRIES(RETRIES)) u_budget (
    .clk(clk), .rst_n(rst_n), .clr(budget_clr), .bump(budget_bump),
    .exhausted(exhausted)
  );

  rsp_seq_fsm #(.RST_OPC(RST_OPC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .rx_valid(rx_valid), .rx_err(rx_err), .hit(hit), .exhausted(exhausted),
    .stage(stage), .opc_q(opc_q), .budget_clr(budget_clr),
    .budget_bump(budget_bump), .rd_req(rd_req), .done(done), .fail(fail)
  );

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> (!done && !fail && !rd_req)); // R1
endmodule

// File: tb/sim_spi_resp_checker.sv
module sim_spi_resp_checker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic rx_valid, rx_err;
  logic [7:0] rx_data;
  logic rd_req, done, fail;

  logic eng_v = 1'b0, eng_e = 1'b0;
  logic stray_v = 1'b0, stray_e = 1'b0;
  logic [7:0] eng_d = 8'h00;
  logic [7:0] script [0:31];
  int idx = 0;
  int err_at = 0;
  int checks = 0, errors = 0, cycles = 0;

  assign rx_valid = eng_v | stray_v;
  assign rx_err   = eng_e | stray_e;
  assign rx_data  = eng_d;

  always #5 clk = ~clk;

  spi_resp_checker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
    .rd_req(rd_req), .done(done), .fail(fail)
  );

  // byte engine model: answers each request one cycle later
  always @(posedge clk) begin
    eng_v <= 1'b0;
    eng_e <= 1'b0;
    if (rd_req) begin
      eng_v <= 1'b1;
      eng_d <= script[idx];
      eng_e <= (idx + 1 == err_at);
      idx   <= idx + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // opcode, echo junk count, status junk count, error read index (0 none)
  localparam logic [31:0] VEC [13] = '{
    {8'hC9, 8'd0,  8'd0,  8'd0},
    {8'hCA, 8'd3,  8'd2,  8'd0},
    {8'hC3, 8'd10, 8'd0,  8'd0},
    {8'hC4, 8'd11, 8'd0,  8'd0},
    {8'hC8, 8'd0,  8'd10, 8'd0},
    {8'hC7, 8'd2,  8'd11, 8'd0},
    {8'hCF, 8'd0,  8'd0,  8'd0},
    {8'hCF, 8'd4,  8'd3,  8'd0},
    {8'hCF, 8'd10, 8'd0,  8'd0},
    {8'hCF, 8'd11, 8'd0,  8'd0},
    {8'hC9, 8'd2,  8'd3,  8'd4},
    {8'hCF, 8'd0,  8'd0,  8'd1},
    {8'hCA, 8'd0,  8'd0,  8'd2}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic void model(input logic [7:0] opc, input int ej, input int sj,
                                input int ea, output bit f, output int n);
    int d = (opc == 8'hCF) ? 1 : 0;
    if (ej > 10) begin n = d + 11; f = 1; end
    else if (sj > 10) begin n = d + ej + 1 + 11; f = 1; end
    else begin n = d + ej + 1 + sj + 1; f = 0; end
    if (ea != 0 && ea <= n) begin n = ea; f = 1; end
  endfunction

  task automatic run(input logic [7:0] opc, input int ej, input int sj,
                     input int ea, input bit poke, input string req);
    int k = 0;
    int reads = 0;
    bit f_exp;
    int n_exp;
    bit got = 0;
    bit prev_v = 0;
    if (opc == 8'hCF) script[k++] = opc;
    for (int i = 0; i < ej; i++) script[k++] = opc ^ 8'h3C;
    script[k++] = opc;
    for (int i = 0; i < sj; i++) script[k++] = 8'hA5;
    script[k++] = 8'h00;
    for (int i = k; i < 32; i++) script[i] = 8'h5A;
    idx = 0;
    err_at = ea;
    model(opc, ej, sj, ea, f_exp, n_exp);
    @(negedge clk);
    opcode = opc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 300 && !got; t++) begin
      if (poke && t == 3) begin start = 1'b1; opcode = ~opc; end  // R8 R9
      if (poke && t == 4) start = 1'b0;
      if (rd_req) reads++;
      if (done) begin
        got = 1;
        chk(fail == f_exp, req, "fail flag", fail, f_exp);
        chk(reads == n_exp, req, "byte reads", reads, n_exp);
        chk(prev_v == 1'b1, "R7", "done follows deciding byte", prev_v, 1);
      end
      prev_v = rx_valid;
      @(negedge clk);
    end
    if (!got) chk(0, req, "done seen", 0, 1);
    else chk(!done && !fail, "R7", "done width one cycle", done, 0);
    start = 1'b0;
    err_at = 0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) script[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done, "R1", "done in reset", done, 0);
    chk(!fail, "R1", "fail in reset", fail, 0);
    chk(!rd_req, "R1", "rd_req in reset", rd_req, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && !rd_req, "R1", "quiet after reset", done | rd_req, 0);

    for (int v = 0; v < 13; v++) begin
      logic [7:0] o = VEC[v][31:24];
      int ej = int'(VEC[v][23:16]);
      int sj = int'(VEC[v][15:8]);
      int ea = int'(VEC[v][7:0]);
      string rq;
      if (ea != 0) rq = "R6";
      else if (o == 8'hCF) rq = "R3";
      else if (ej > 10 || ej == 10) rq = "R4";
      else rq = "R5";
      run(o, ej, sj, ea, 0, rq);
    end

    // R2 request latency: rd_req in the cycle after start
    idx = 0;
    script[0] = 8'hC9; script[1] = 8'h00;
    @(negedge clk);
    opcode = 8'hC9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(rd_req == 1'b1, "R2", "rd_req after start", rd_req, 1);
    @(negedge clk);
    chk(rd_req == 1'b0, "R2", "single request pulse", rd_req, 0);
    repeat (6) @(negedge clk);

    // R8 R9: start and opcode changes mid-check are ignored
    run(8'hCA, 3, 2, 0, 1, "R8");

    // R8: stray byte with error while idle has no effect
    @(negedge clk);
    stray_v = 1'b1; stray_e = 1'b1;
    @(negedge clk);
    stray_v = 1'b0; stray_e = 1'b0;
    for (int t = 0; t < 3; t++) begin
      chk(!done && !rd_req, "R8", "stray byte ignored", done | rd_req, 0);
      @(negedge clk);
    end
    run(8'hC9, 1, 1, 0, 0, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule